// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block brings a clock generator into and out of its low-power state. An asynchronous, active-low power-down pin is brought into the internal CPU clock domain first. The block then orders every clock output group to park low, and these holds take effect on a falling edge of the internal clock. The block waits until each output group reports that it is parked. Only after that does it drop the crystal-oscillator and VCO enables. The block stays down until the pin is released.

On release the block turns the oscillator and VCO back on and waits a parameterised stabilisation count, `STAB_CYCLES`, which stands in for PLL lock. It then releases the output holds and raises `ready`. An active-low CPU-stop input parks the CPU group while the block is running normally. The block ignores that input in every state of the power-down sequence.

A power-down request that arrives while the block is stabilising is held off. The block finishes stabilising, runs for one cycle, and then enters the down sequence again.

Top module: `pwrdn_seq`

## Requirements
- R1: `pdReqN` passes through two synchronizer flops and one confirm state, so no hold output changes in the first three rising edges after the pin falls.
- R2: All `grpHold` bits are high when sampled after the falling edge that follows the fourth rising edge after the pin falls. The holds stay high until stabilisation ends.
- R3: `oscEn` and `vcoEn` stay high until every `grpParked` bit is high. Both drop together on the second rising edge after the cycle in which the last park acknowledge arrives.
- R4: While running, a low on `cpuStopN` sets only `grpHold[0]` (group 0 is the CPU group) two rising edges later, at the next falling edge. Releasing the input clears that hold two rising edges after release. In all other states `cpuStopN` has no effect on any output.
- R5: After `pdReqN` rises in the down state, both enables return high on the fourth rising edge. `ready` rises and the holds clear exactly `STAB_CYCLES` rising edges after that.
- R6: Reset drives every hold high, both enables high and `ready` low. `ready` rises and the holds clear on the `STAB_CYCLES`-th rising edge after reset release.
- R7: A request that arrives during stabilisation does not shorten it. `ready` goes high for exactly one cycle and the entry sequence then starts again.
- R8: Once the holds have been raised, entry runs to completion even if the pin is released early. Exit then begins at once.
- R9: `ready` is high only in normal running, and only when both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReqN | input | 1 | Asynchronous active-low power-down pin |
| cpuStopN | input | 1 | Asynchronous active-low CPU clock stop |
| grpParked | input | NUM_GRP | Per-group acknowledge that its outputs sit low (0 CPU, 1 PCI, 2 SDRAM, 3 reference, 4 48 MHz) |
| grpHold | output | NUM_GRP | Per-group hold-low command, updated on falling edges |
| oscEn | output | 1 | Crystal oscillator enable |
| vcoEn | output | 1 | PLL VCO enable |
| ready | output | 1 | Clocks valid and running |

## Verification
Two events can fall in the same cycle. A new power-down request can finish synchronising on the very edge where stabilisation completes. Likewise, the pin can be released while the block is still waiting for park acknowledges. The bench drops the pin exactly two cycles before the stabilisation count expires. It then checks that `ready` is high for one cycle and that the holds fall and rise again on the predicted edges. In other runs it releases the pin right after the holds rise and delays the reference-group acknowledge. It then checks that the enables still drop and that they return on the predicted edge.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SYNC, ST_HOLD, ST_OSC_OFF, ST_DOWN, ST_OSC_ON, ST_STAB
  } pdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdReq;    // park every group low
    logic cpuGateEn;  // CPU-stop input may act
    logic oscOff;     // drop oscillator and VCO enables
    logic oscOn;      // raise oscillator and VCO enables
    logic stabLoad;   // start the stabilisation count
  } pdCtrl_t;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_ctl.sv
module pwrdn_ctl
  import pwrdn_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pdAct,
  input  logic    allParked,
  input  logic    stabDone,
  output pdCtrl_t ctrl,
  output logic    ready
);
  pdState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STAB;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:     if (pdAct) stateNxt = ST_SYNC;
      ST_SYNC:    stateNxt = ST_HOLD;
      ST_HOLD:    if (allParked) stateNxt = ST_OSC_OFF;
      ST_OSC_OFF: stateNxt = ST_DOWN;
      ST_DOWN:    if (!pdAct) stateNxt = ST_OSC_ON;
      ST_OSC_ON:  stateNxt = ST_STAB;
      ST_STAB:    if (stabDone) stateNxt = ST_RUN;
      default:    stateNxt = ST_STAB;
    endcase
  end

  always_comb begin
    ctrl.holdReq   = (state != ST_RUN) && (state != ST_SYNC);
    ctrl.cpuGateEn = (state == ST_RUN);
    ctrl.oscOff    = (state == ST_OSC_OFF);
    ctrl.oscOn     = (state == ST_OSC_ON);
    ctrl.stabLoad  = (state == ST_OSC_ON);
  end

  assign ready = (state == ST_RUN);

  // R1: confirm state only after the synchronised request was seen
  a_r1_sync_after_req: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC) |-> $past(pdAct));
  // R3: oscillators go off only after every group acknowledged
  a_r3_off_after_park: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OSC_OFF) |-> $past(allParked));
  // R7: a request cannot cut stabilisation short
  a_r7_stab_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STAB && !stabDone) |=> (state == ST_STAB));
endmodule

// File: rtl/pwrdn_dp.sv
module pwrdn_dp
  import pwrdn_pkg::*;
#(
  parameter int NUM_GRP     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 200000,
  parameter int CPU_GRP     = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdReqN,
  input  logic               cpuStopN,
  input  logic [NUM_GRP-1:0] grpParked,
  input  pdCtrl_t            ctrl,
  output logic               pdAct,
  output logic               allParked,
  output logic               stabDone,
  output logic [NUM_GRP-1:0] grpHold,
  output logic               oscEn,
  output logic               vcoEn
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES - 1);

  logic pdSync, cpuSync, cpuStopAct;
  logic [CNT_W-1:0] stabCnt;

  pwrdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uPdSync (
    .clk(clk), .rstN(rstN), .din(pdReqN), .dout(pdSync));
  pwrdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uCpuSync (
    .clk(clk), .rstN(rstN), .din(cpuStopN), .dout(cpuSync));

  assign pdAct      = !pdSync;
  assign cpuStopAct = !cpuSync;
  assign allParked  = &grpParked;
  assign stabDone   = (stabCnt == '0);

  // stabilisation timer, started when the oscillators come back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stabCnt <= CNT_LOAD;
    else if (ctrl.stabLoad)  stabCnt <= CNT_LOAD;
    else if (stabCnt != '0)  stabCnt <= stabCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn <= 1'b1;
      vcoEn <= 1'b1;
    end else if (ctrl.oscOff) begin
      oscEn <= 1'b0;
      vcoEn <= 1'b0;
    end else if (ctrl.oscOn) begin
      oscEn <= 1'b1;
      vcoEn <= 1'b1;
    end
  end

  // hold-low registers change on the falling edge of the CPU clock
  for (genvar g = 0; g < NUM_GRP; g++) begin : gHold
    logic holdQ;
    if (g == CPU_GRP) begin : gCpu
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN)               holdQ <= 1'b1;
        else if (ctrl.holdReq)   holdQ <= 1'b1;
        else if (ctrl.cpuGateEn) holdQ <= cpuStopAct;
      end
    end else begin : gStd
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) holdQ <= 1'b1;
        else       holdQ <= ctrl.holdReq;
      end
    end
    assign grpHold[g] = holdQ;
  end

  // R2: while parking is requested every group is held
  a_r2_hold_all: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdReq |-> (&grpHold));
  // R3: enables fall only with all outputs held and acknowledged
  a_r3_fall_ordered: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscEn) |-> ((&grpHold) && $past(allParked, 2)));
  // R4: outside normal running the CPU-stop input moves nothing
  a_r4_cpu_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.cpuGateEn && !ctrl.holdReq) |-> $stable(grpHold[CPU_GRP]));
  // R5: enables return only once the request is gone
  a_r5_rise_released: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> !$past(pdAct, 2));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int NUM_GRP     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 200000,
  parameter int CPU_GRP     = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdReqN,
  input  logic               cpuStopN,
  input  logic [NUM_GRP-1:0] grpParked,
  output logic [NUM_GRP-1:0] grpHold,
  output logic               oscEn,
  output logic               vcoEn,
  output logic               ready
);
  pdCtrl_t ctrl;
  logic pdAct, allParked, stabDone;

  pwrdn_ctl uCtl (
    .clk(clk), .rstN(rstN), .pdAct(pdAct), .allParked(allParked),
    .stabDone(stabDone), .ctrl(ctrl), .ready(ready));

  pwrdn_dp #(
    .NUM_GRP(NUM_GRP), .SYNC_STAGES(SYNC_STAGES),
    .STAB_CYCLES(STAB_CYCLES), .CPU_GRP(CPU_GRP)
  ) uDp (
    .clk(clk), .rstN(rstN), .pdReqN(pdReqN), .cpuStopN(cpuStopN),
    .grpParked(grpParked), .ctrl(ctrl), .pdAct(pdAct),
    .allParked(allParked), .stabDone(stabDone), .grpHold(grpHold),
    .oscEn(oscEn), .vcoEn(vcoEn));

  // R9: clocks are declared valid only with both sources running
  a_r9_ready_sources: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (oscEn && vcoEn));
endmodule

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
  localparam int NG = 5;
  localparam int STAB = 12;
  localparam int REF_GRP = 3;

  logic clk = 1'b0, rstN = 1'b0, pdReqN = 1'b1, cpuStopN = 1'b1;
  logic [NG-1:0] parked = '0;
  logic [NG-1:0] grpHold;
  logic oscEn, vcoEn, ready;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrdn_seq #(.NUM_GRP(NG), .STAB_CYCLES(STAB)) u0 (
    .clk(clk), .rstN(rstN), .pdReqN(pdReqN), .cpuStopN(cpuStopN),
    .grpParked(parked), .grpHold(grpHold), .oscEn(oscEn),
    .vcoEn(vcoEn), .ready(ready));

  function automatic logic [NG-1:0] holdMask(bit all, bit cpu);
    return all ? {NG{1'b1}} : {{(NG-1){1'b0}}, cpu};
  endfunction
  function automatic int enRiseSteps(int pre); return 4 - pre; endfunction

  // one rising edge, then a point after the following falling edge
  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #7; end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enter(int pre, bit earlyRel);
    int d[NG];
    if (pre == 0) pdReqN = 1'b0;
    step(3 - pre);
    chk("R1 holds unchanged during sync", grpHold, holdMask(0, 0));
    chk("R7 and R9 ready low on entry", ready, 0);
    step(1);
    chk("R2 all groups held", grpHold, holdMask(1, 0));
    if (earlyRel) pdReqN = 1'b1;   // R8
    for (int g = 0; g < NG; g++)
      d[g] = (g == REF_GRP) ? $urandom_range(2, 6) : $urandom_range(0, 2);
    for (int t = 0; t < 16; t++) begin
      for (int g = 0; g < NG; g++) if (d[g] <= t) parked[g] = 1'b1;
      if (&parked) break;
      step(1);
      chk("R3 enables held while parking", {oscEn, vcoEn}, 2'b11);
    end
    step(1);
    chk("R3 enables one edge after park", {oscEn, vcoEn}, 2'b11);
    step(1);
    chk("R3 enables dropped", {oscEn, vcoEn}, 2'b00);
  endtask

  task automatic leave(int pre, int downLen, bit reenter);
    for (int i = 0; i < downLen; i++) begin
      cpuStopN = 1'($urandom_range(0, 1));
      step(1);
      chk("R4 down state ignores cpu stop", {grpHold, oscEn, vcoEn, ready},
          {holdMask(1, 0), 3'b000});
    end
    cpuStopN = 1'b1;
    if (pre == 0) pdReqN = 1'b1;
    step(enRiseSteps(pre) - 1);
    chk("R5 enables still off", {oscEn, vcoEn}, 2'b00);
    step(1);
    chk("R5 and R8 enables back", {oscEn, vcoEn}, 2'b11);
    for (int i = 1; i < STAB; i++) begin
      if (reenter && i == STAB - 1) pdReqN = 1'b0;
      step(1);
      chk("R5 ready low while stabilising", ready, 0);
    end
    step(1);
    chk("R5 and R7 ready after count", ready, 1);
    chk("R5 holds released", grpHold, holdMask(0, 0));
    parked = '0;
  endtask

  task automatic cpuStopPulse();
    cpuStopN = 1'b0;
    step(1);
    chk("R4 cpu stop sync", grpHold, holdMask(0, 0));
    step(1);
    chk("R4 cpu group parked", grpHold, holdMask(0, 1));
    cpuStopN = 1'b1;
    step(1);
    chk("R4 cpu held during release sync", grpHold, holdMask(0, 1));
    step(1);
    chk("R4 cpu group released", grpHold, holdMask(0, 0));
  endtask

  initial begin
    void'($urandom(32'd2024));
    step(2);
    chk("R6 reset holds", grpHold, holdMask(1, 0));
    chk("R6 reset enables", {oscEn, vcoEn}, 2'b11);
    chk("R6 reset ready", ready, 0);
    rstN = 1'b1;
    step(STAB - 1);
    chk("R6 ready low before count", ready, 0);
    step(1);
    chk("R6 ready after count", ready, 1);
    chk("R6 holds released", grpHold, holdMask(0, 0));
    step(2);
    cpuStopPulse();
    // plain cycle
    enter(0, 0); leave(0, 3, 0);
    // request lands on the last stabilisation edge
    enter(0, 0); leave(0, 2, 1); enter(2, 0); leave(0, 1, 0);
    // pin released before parking finishes
    enter(0, 1); leave(2, 0, 0);
    for (int it = 0; it < 10; it++) begin
      bit er, re;
      er = 1'($urandom_range(0, 1));
      re = 1'($urandom_range(0, 1));
      step($urandom_range(1, 4));
      if ($urandom_range(0, 1) == 1) begin cpuStopPulse(); step(1); end
      enter(0, er);
      if (er) leave(2, 0, re);
      else    leave(0, $urandom_range(1, 6), re);
      if (re) begin enter(2, 0); leave(0, 2, 0); end
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule